// File: doc/BRIEF.md
# Processor Control and Status Register

A 32-bit control and status word owned by one processor and reached through a simple register port. A write is a single-cycle strobe carrying a full data word, and the read value is presented combinationally at all times. Each bit position has its own write behaviour. Some bits are ordinary storage. Three are sticky event flags that hardware sets and software clears by writing a one. Two positions are write-only strobes that tell external interrupt sources to drop their requests.

On every read, two live interrupt-request inputs appear at fixed positions: the console request and this processor's inter-processor request. A four-bit event code is captured when the event-lock flag first sets, and it is held while that flag stays set. A parameter chooses the primary or the secondary reset image. The secondary image also raises the restart-halt and logical-console status bits.

Top module: `proc_csr`

## Requirements
- R1: After reset, the read value is 0x2700_0000 when SECONDARY=0 and 0xE700_0000 when SECONDARY=1, provided both live interrupt inputs are low. Bit 24 is the stored run bit. Bits 29, 26 and 25 are fixed status bits. The secondary image also holds bits 31 and 30.
- R2: A write loads bits 24, 23, 15, 13, 10, 7 and 2 (mask 0x0180_A484) from the data word. These bits keep their value in cycles without a write.
- R3: Writes never change bits 31:25, 21:20, 11, 6:5 or 1:0. Bits 28, 27, 11, 21, 20, 6, 5, 1 and 0 always read 0.
- R4: A one-cycle pulse on parerr_set_i, timeout_set_i or evlock_set_i sets bit 14, bit 12 or bit 22 respectively from the next cycle on. The bit stays set until it is cleared.
- R5: Writing a 1 to bit 22, 14 or 12 clears that flag from the next cycle on. Writing a 0 to it leaves it unchanged.
- R6: When a set pulse and a clearing write for the same flag fall in the same cycle, the flag is set afterwards.
- R7: con_clr_o is high in exactly the cycles that carry a write with data bit 9 set. ipi_clr_o is high in exactly the cycles that carry a write with data bit 4 set.
- R8: Read bit 8 equals con_irq_i and read bit 3 equals ipi_irq_i in the same cycle.
- R9: Bits 9 and 4 always read 0.
- R10: Bits 19:16 take event_code_i on the cycle after an evlock_set_i pulse that arrives while bit 22 is clear. They stay unchanged while bit 22 is set and in every other cycle. They reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 32 | Write data word |
| rd_data | output | 32 | Combinational read value |
| con_irq_i | input | 1 | Live console interrupt request |
| ipi_irq_i | input | 1 | Live inter-processor request for this processor |
| evlock_set_i | input | 1 | Event-lock set pulse |
| parerr_set_i | input | 1 | Parity-error set pulse |
| timeout_set_i | input | 1 | Timeout set pulse |
| event_code_i | input | 4 | Event code, captured when event lock sets |
| con_clr_o | output | 1 | Strobe to clear the console request |
| ipi_clr_o | output | 1 | Strobe to clear the inter-processor request |

## Verification
The assertions assume that the set pulses, the write strobe and the write data are stable for a whole cycle around each rising edge, and that they carry no other timing meaning. The flag properties hold for any pattern of pulses and writes. The stimulus changes every input one nanosecond after a rising edge and holds it until the next edge. It deliberately places set pulses in the same cycle as clearing writes, and it pulses event lock again while the flag is already held.

// File: rtl/proc_csr.sv
module proc_csr #(
  parameter bit SECONDARY = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        con_irq_i,
  input  logic        ipi_irq_i,
  input  logic        evlock_set_i,
  input  logic        parerr_set_i,
  input  logic        timeout_set_i,
  input  logic [3:0]  event_code_i,
  output logic        con_clr_o,
  output logic        ipi_clr_o
);
  localparam logic [31:0] RW_MASK  = 32'h0180_A484;
  localparam logic [31:0] RW_RESET = 32'h0100_0000;
  localparam logic [31:0] FIXED    = 32'h2600_0000 | (SECONDARY ? 32'hC000_0000 : 32'h0);
  localparam int LOCK_B = 22;
  localparam int PAR_B  = 14;
  localparam int TMO_B  = 12;
  localparam int CCLR_B = 9;
  localparam int CON_B  = 8;
  localparam int ICLR_B = 4;
  localparam int IPI_B  = 3;

  logic [31:0] rw_q;
  logic        lock_q, par_q, tmo_q;
  logic [3:0]  code_q;

  wire clr_lock = wr_en & wr_data[LOCK_B];
  wire clr_par  = wr_en & wr_data[PAR_B];
  wire clr_tmo  = wr_en & wr_data[TMO_B];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rw_q   <= RW_RESET;
      lock_q <= 1'b0;
      par_q  <= 1'b0;
      tmo_q  <= 1'b0;
      code_q <= 4'h0;
    end else begin
      if (wr_en) rw_q <= wr_data & RW_MASK;
      lock_q <= evlock_set_i  | (lock_q & ~clr_lock);
      par_q  <= parerr_set_i  | (par_q  & ~clr_par);
      tmo_q  <= timeout_set_i | (tmo_q  & ~clr_tmo);
      if (evlock_set_i && !lock_q) code_q <= event_code_i;
    end
  end

  always_comb begin
    rd_data         = FIXED | rw_q;
    rd_data[LOCK_B] = lock_q;
    rd_data[19:16]  = code_q;
    rd_data[PAR_B]  = par_q;
    rd_data[TMO_B]  = tmo_q;
    rd_data[CON_B]  = con_irq_i;
    rd_data[IPI_B]  = ipi_irq_i;
  end

  assign con_clr_o = wr_en & wr_data[CCLR_B];
  assign ipi_clr_o = wr_en & wr_data[ICLR_B];
endmodule

// File: rtl/proc_csr_chk.sv
module proc_csr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        parerr_set_i,
  input logic        timeout_set_i
);
  // R2
  rw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((rd_data & 32'h0180_A484) == ($past(rd_data) & 32'h0180_A484)));

  // R3
  ro_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(rd_data[31:25]));

  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[14] && !(wr_en && wr_data[14])) |=> rd_data[14]);

  // R5
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[12] && !timeout_set_i) |=> !rd_data[12]);

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parerr_set_i |=> rd_data[14]);

  // R10
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[22] |=> (rd_data[19:16] == $past(rd_data[19:16])));

  // R9
  strobe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[9] == 1'b0) && (rd_data[4] == 1'b0));
endmodule

bind proc_csr proc_csr_chk chk_i (.*);

// File: tb/tb_proc_csr.sv
`timescale 1ns/1ps
module tb_proc_csr;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, wr_en, con_irq_i, ipi_irq_i;
  logic        evlock_set_i, parerr_set_i, timeout_set_i;
  logic [31:0] wr_data, rd_data, rd_sec;
  logic [3:0]  event_code_i;
  logic        con_clr_o, ipi_clr_o, cc_sec, ic_sec;

  proc_csr #(.SECONDARY(1'b0)) dut (
    .clk, .rst_n, .wr_en, .wr_data, .rd_data, .con_irq_i, .ipi_irq_i,
    .evlock_set_i, .parerr_set_i, .timeout_set_i, .event_code_i,
    .con_clr_o, .ipi_clr_o);

  proc_csr #(.SECONDARY(1'b1)) dut_sec (
    .clk, .rst_n, .wr_en, .wr_data, .rd_data(rd_sec), .con_irq_i, .ipi_irq_i,
    .evlock_set_i, .parerr_set_i, .timeout_set_i, .event_code_i,
    .con_clr_o(cc_sec), .ipi_clr_o(ic_sec));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] q_rd[$];
  logic        q_cc[$];
  logic        q_ic[$];
  string       q_tag[$];

  logic [31:0] m_rw = 32'h0100_0000;
  logic        m_lock = 0, m_par = 0, m_tmo = 0;
  logic [3:0]  m_code = 0;

  task automatic cyc(input logic wen, input logic [31:0] wd, input logic con, input logic ipi,
                     input logic s_ev, input logic s_par, input logic s_tmo,
                     input logic [3:0] code, input string tag);
    logic [31:0] e;
    @(posedge clk); #1;
    wr_en = wen; wr_data = wd; con_irq_i = con; ipi_irq_i = ipi;
    evlock_set_i = s_ev; parerr_set_i = s_par; timeout_set_i = s_tmo; event_code_i = code;
    e = 32'h2600_0000 | m_rw;
    e[22] = m_lock; e[19:16] = m_code; e[14] = m_par; e[12] = m_tmo;
    e[8] = con; e[3] = ipi;
    q_rd.push_back(e); q_cc.push_back(wen & wd[9]); q_ic.push_back(wen & wd[4]);
    q_tag.push_back(tag);
    if (wen) m_rw = wd & 32'h0180_A484;
    if (s_ev && !m_lock) m_code = code;
    m_lock = s_ev  | (m_lock & !(wen & wd[22]));
    m_par  = s_par | (m_par  & !(wen & wd[14]));
    m_tmo  = s_tmo | (m_tmo  & !(wen & wd[12]));
  endtask

  always @(negedge clk) begin
    if (q_rd.size() > 0) begin
      logic [31:0] e; logic cc, ic; string t;
      e = q_rd.pop_front(); cc = q_cc.pop_front(); ic = q_ic.pop_front(); t = q_tag.pop_front();
      checks++;
      if (rd_data !== e || con_clr_o !== cc || ipi_clr_o !== ic) begin
        fails++;
        $display("FAIL %s: rd=%h cc=%b ic=%b expected rd=%h cc=%b ic=%b",
                 t, rd_data, con_clr_o, ipi_clr_o, e, cc, ic);
      end
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_up();
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_data = 0; con_irq_i = 0; ipi_irq_i = 0;
    evlock_set_i = 0; parerr_set_i = 0; timeout_set_i = 0; event_code_i = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #2;
    // R1 reset images of both variants
    checks++;
    if (rd_data !== 32'h2700_0000) begin
      fails++; $display("FAIL R1: primary rd=%h expected %h", rd_data, 32'h2700_0000);
    end
    checks++;
    if (rd_sec !== 32'hE700_0000) begin
      fails++; $display("FAIL R1: secondary rd=%h expected %h", rd_sec, 32'hE700_0000);
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R1 idle");
    // R2 R3 R7 all-ones write, then partial patterns
    cyc(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, "R7 both strobes");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R2 R3 after ones");
    cyc(1, 32'h0000_0004, 0, 0, 0, 0, 0, 0, "R2 partial");
    cyc(1, 32'h1883_0800, 0, 0, 0, 0, 0, 0, "R3 ro write");
    cyc(1, 32'h0000_0200, 0, 0, 0, 0, 0, 0, "R7 console strobe");
    cyc(1, 32'h0000_0010, 0, 0, 0, 0, 0, 0, "R7 ipi strobe");
    // R8 R9 live inputs
    cyc(0, 0, 1, 0, 0, 0, 0, 0, "R8 console live");
    cyc(0, 0, 0, 1, 0, 0, 0, 0, "R8 ipi live");
    cyc(0, 0, 1, 1, 0, 0, 0, 0, "R8 R9 both live");
    // R4 R5 sticky flags
    cyc(0, 0, 0, 0, 0, 1, 0, 0, "R4 parity pulse");
    cyc(1, 32'h0000_1000, 0, 0, 0, 0, 1, 0, "R4 timeout pulse");
    cyc(1, 32'h0000_0000, 0, 0, 0, 0, 0, 0, "R5 zero write keeps");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R4 hold");
    cyc(1, 32'h0000_4000, 0, 0, 0, 0, 0, 0, "R5 clear parity");
    cyc(1, 32'h0000_1000, 0, 0, 0, 0, 0, 0, "R5 clear timeout");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R5 cleared");
    // R6 set wins
    cyc(1, 32'h0040_5000, 0, 0, 1, 1, 1, 4'h6, "R6 set and clear");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R6 flags set");
    // R10 event code capture
    cyc(0, 0, 0, 0, 1, 0, 0, 4'h5, "R10 relock ignored");
    cyc(1, 32'h0040_5000, 0, 0, 0, 0, 0, 4'h9, "R10 code held");
    cyc(0, 0, 0, 0, 1, 0, 0, 4'hA, "R10 capture after clear");
    cyc(0, 0, 0, 0, 0, 0, 0, 4'h3, "R10 code kept");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R10 final");
    @(posedge clk); #1;
    wr_en = 0; evlock_set_i = 0; parerr_set_i = 0; timeout_set_i = 0;
    while (q_rd.size() > 0) @(negedge clk);
    @(posedge clk);
    finish_up();
  end
endmodule